// File: doc/BRIEF.md
# Calendar alarm comparator

This block watches the running BCD calendar (seconds, minutes, hours with a PM bit, weekday, day of month, month and two-digit year) and raises an alarm flag when the calendar reaches a programmed moment. Each field of the programmed moment has its own enable bit. A field whose enable is clear takes no part in the comparison, so software can build alarms such as "every day at 07:30:00" or "on the 15th of any month". The year value has no spare bit, so its enable sits in a register of its own.

The calendar counter delivers its fields together with a one-cycle `cal_tick` strobe in the cycle after it updates, which is about once a second. The comparison runs only on that strobe. The flag is set when the calendar moves into a full match, not for every second the match lasts. Software clears the flag by writing 0 to it. An interrupt enable gates the flag onto `alarm_irq`. After any alarm register is rewritten, the comparison takes no action until two periodic ticks (`per_tick`, 1/64 s apart) have passed. This keeps a half-written alarm from firing.

Access uses a byte-wide register port with a combinational read path. Flag and enable share bit 0 of their registers.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset every register reads 0x00 and `alarm_irq` is low.
- R2: Register map and stored bits, read back as written through these masks. Address 0 seconds (mask 0xFF), 1 minutes (0xFF), 2 hours (0xFF), 3 weekday (0x87), 4 day (0xBF), 5 month (0x9F), 6 year value (0xFF), 7 year enable (0x80), 8 control (0x01), 9 status (0x01). Other addresses read 0.
- R3: In the field registers at addresses 0 to 5, bit 7 is the field enable and the low bits hold the BCD value. For hours the low bits are bits 6:0, and bit 6 is the PM bit, which is compared as well. When every enabled field equals the calendar on a `cal_tick`, status bit 0 is set in the next cycle.
- R4: A field whose enable bit is clear is excluded from the comparison, so a difference in that field does not prevent the alarm.
- R5: A difference in any enabled field prevents the flag from being set.
- R6: The year comparison is enabled by bit 7 of address 7. All 8 bits of address 6 are year data.
- R7: If every enable is clear, the flag is never set.
- R8: A write to addresses 0 to 7 restarts a count of `per_tick` pulses. The flag cannot be set until two pulses have been counted since the last such write. Reset also starts the count from zero.
- R9: The flag is set only on a `cal_tick` where the match is true and the match at the previous `cal_tick` was false. A match that persists does not set the flag again after it is cleared.
- R10: Writing status with bit 0 = 0 clears the flag, and writing bit 0 = 1 leaves it unchanged. A match that sets the flag in the same cycle as a clear takes priority.
- R11: `alarm_irq` is high exactly when the flag is set and control bit 0 (alarm interrupt enable) is 1.
- R12: No comparison takes place without `cal_tick`, even when the calendar matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_tick | input | 1 | One-cycle strobe after the calendar updates |
| per_tick | input | 1 | One-cycle strobe at each 1/64 s periodic tick |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 7 | Calendar hours, BCD in 5:0, PM in bit 6 |
| cal_wday | input | 3 | Calendar weekday |
| cal_day | input | 6 | Calendar day of month, BCD |
| cal_mon | input | 5 | Calendar month, BCD |
| cal_year | input | 8 | Calendar year, BCD |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
A wrong enable or stored field value shows up directly in the register readback. It also shows up in the status flag one cycle after the first `cal_tick` that should or should not match. A stale previous-match bit or a wrong settle count shows up one tick late: the flag is missing or extra on the next strobe, so the checks place non-matching calendar strobes between matches to separate the two. A fault in interrupt gating reaches `alarm_irq` in the same cycle that the control or status bit changes.

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
  parameter int SETTLE_TICKS = 2,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_tick,
  input  logic          per_tick,
  input  logic [6:0]    cal_sec,
  input  logic [6:0]    cal_min,
  input  logic [6:0]    cal_hour,
  input  logic [2:0]    cal_wday,
  input  logic [5:0]    cal_day,
  input  logic [4:0]    cal_mon,
  input  logic [7:0]    cal_year,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          alarm_irq
);
  localparam logic [AW-1:0] A_SEC  = AW'(0);
  localparam logic [AW-1:0] A_MIN  = AW'(1);
  localparam logic [AW-1:0] A_HOUR = AW'(2);
  localparam logic [AW-1:0] A_WDAY = AW'(3);
  localparam logic [AW-1:0] A_DAY  = AW'(4);
  localparam logic [AW-1:0] A_MON  = AW'(5);
  localparam logic [AW-1:0] A_YEAR = AW'(6);
  localparam logic [AW-1:0] A_YEN  = AW'(7);
  localparam logic [AW-1:0] A_CTRL = AW'(8);
  localparam logic [AW-1:0] A_STAT = AW'(9);
  localparam int CW = $clog2(SETTLE_TICKS + 1);
  localparam logic [CW-1:0] SETTLE_DONE = CW'(SETTLE_TICKS);

  logic [7:0] ar_sec, ar_min, ar_hour, ar_wday, ar_day, ar_mon, ar_year;
  logic       yen_q, aie_q, flag_q, prev_q;
  logic [CW-1:0] settle_q;
  logic [6:0] fld_en, fld_hit;
  logic       any_en, full_match, settled, alarm_wr, set_flag, clr_flag;

  assign fld_en  = {yen_q, ar_mon[7], ar_day[7], ar_wday[7], ar_hour[7], ar_min[7], ar_sec[7]};
  assign fld_hit = {ar_year    == cal_year,
                    ar_mon[4:0] == cal_mon,
                    ar_day[5:0] == cal_day,
                    ar_wday[2:0] == cal_wday,
                    ar_hour[6:0] == cal_hour,
                    ar_min[6:0]  == cal_min,
                    ar_sec[6:0]  == cal_sec};

  assign any_en     = |fld_en;
  assign full_match = any_en && (&(~fld_en | fld_hit));
  assign settled    = (settle_q == SETTLE_DONE);
  assign alarm_wr   = reg_we && (reg_addr <= A_YEN);
  assign set_flag   = cal_tick && full_match && !prev_q && settled;
  assign clr_flag   = reg_we && (reg_addr == A_STAT) && !reg_wdata[0];
  assign alarm_irq  = flag_q & aie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_sec  <= '0;
      ar_min  <= '0;
      ar_hour <= '0;
      ar_wday <= '0;
      ar_day  <= '0;
      ar_mon  <= '0;
      ar_year <= '0;
      yen_q   <= 1'b0;
      aie_q   <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_SEC:  ar_sec  <= reg_wdata;
        A_MIN:  ar_min  <= reg_wdata;
        A_HOUR: ar_hour <= reg_wdata;
        A_WDAY: ar_wday <= reg_wdata & 8'h87;
        A_DAY:  ar_day  <= reg_wdata & 8'hBF;
        A_MON:  ar_mon  <= reg_wdata & 8'h9F;
        A_YEAR: ar_year <= reg_wdata;
        A_YEN:  yen_q   <= reg_wdata[7];
        A_CTRL: aie_q   <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      settle_q <= '0;
    else if (alarm_wr)
      settle_q <= '0;
    else if (per_tick && !settled)
      settle_q <= settle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cal_tick)
        prev_q <= full_match;
      if (set_flag)
        flag_q <= 1'b1;
      else if (clr_flag)
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_SEC:  reg_rdata = ar_sec;
      A_MIN:  reg_rdata = ar_min;
      A_HOUR: reg_rdata = ar_hour;
      A_WDAY: reg_rdata = ar_wday;
      A_DAY:  reg_rdata = ar_day;
      A_MON:  reg_rdata = ar_mon;
      A_YEAR: reg_rdata = ar_year;
      A_YEN:  reg_rdata = {yen_q, 7'd0};
      A_CTRL: reg_rdata = {7'd0, aie_q};
      A_STAT: reg_rdata = {7'd0, flag_q};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/cal_alarm_match_chk.sv
module cal_alarm_match_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cal_tick,
  input logic          flag,
  input logic          aie,
  input logic          settled,
  input logic          any_en,
  input logic          alarm_irq,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_wdata
);
  p_irq_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> aie);

  p_flag_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(cal_tick));

  p_flag_after_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(settled));

  p_no_field_no_alarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !any_en) |=> !flag);

  p_write_one_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && reg_we && reg_addr == AW'(9) && reg_wdata[0]) |=> flag);
endmodule

bind cal_alarm_match cal_alarm_match_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_tick(cal_tick), .flag(flag_q), .aie(aie_q),
  .settled(settled), .any_en(any_en), .alarm_irq(alarm_irq),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/test_cal_alarm_match.sv
module test_cal_alarm_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_tick = 1'b0, per_tick = 1'b0;
  logic [6:0] cal_sec = '0, cal_min = '0, cal_hour = '0;
  logic [2:0] cal_wday = '0;
  logic [5:0] cal_day = '0;
  logic [4:0] cal_mon = '0;
  logic [7:0] cal_year = '0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic alarm_irq;
  int n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  cal_alarm_match i_cal_alarm_match (
    .clk(clk), .rst_n(rst_n), .cal_tick(cal_tick), .per_tick(per_tick),
    .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour), .cal_wday(cal_wday),
    .cal_day(cal_day), .cal_mon(cal_mon), .cal_year(cal_year),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
  );

  typedef struct packed {
    logic [6:0] en;
    logic [6:0] s;
    logic [6:0] m;
    logic [6:0] h;
    logic [2:0] w;
    logic [5:0] d;
    logic [4:0] mo;
    logic [7:0] y;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{7'h7F, 7'h45, 7'h30, 7'h52, 3'd3, 6'h15, 5'h11, 8'h27, 1'b1},
    '{7'h7F, 7'h46, 7'h30, 7'h52, 3'd3, 6'h15, 5'h11, 8'h27, 1'b0},
    '{7'h7E, 7'h46, 7'h30, 7'h52, 3'd3, 6'h15, 5'h11, 8'h27, 1'b1},
    '{7'h7F, 7'h45, 7'h30, 7'h12, 3'd3, 6'h15, 5'h11, 8'h27, 1'b0},
    '{7'h40, 7'h00, 7'h00, 7'h00, 3'd0, 6'h00, 5'h00, 8'h27, 1'b1},
    '{7'h40, 7'h00, 7'h00, 7'h00, 3'd0, 6'h00, 5'h00, 8'h28, 1'b0},
    '{7'h00, 7'h45, 7'h30, 7'h52, 3'd3, 6'h15, 5'h11, 8'h27, 1'b0},
    '{7'h18, 7'h01, 7'h02, 7'h03, 3'd3, 6'h15, 5'h09, 8'h99, 1'b1},
    '{7'h7F, 7'h45, 7'h30, 7'h52, 3'd3, 6'h15, 5'h12, 8'h27, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_cal();
    @(negedge clk); cal_tick = 1'b1;
    @(negedge clk); cal_tick = 1'b0;
  endtask

  task automatic pulse_per();
    @(negedge clk); per_tick = 1'b1;
    @(negedge clk); per_tick = 1'b0;
  endtask

  task automatic set_cal(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                         input logic [2:0] w, input logic [5:0] d, input logic [4:0] mo,
                         input logic [7:0] y);
    @(negedge clk);
    cal_sec = s; cal_min = m; cal_hour = h; cal_wday = w;
    cal_day = d; cal_mon = mo; cal_year = y;
  endtask

  task automatic prog(input logic [6:0] en);
    wr(4'd0, {en[0], 7'h45});
    wr(4'd1, {en[1], 7'h30});
    wr(4'd2, {en[2], 7'h52});
    wr(4'd3, {en[3], 7'd3});
    wr(4'd4, {en[4], 7'h15});
    wr(4'd5, {en[5], 7'h11});
    wr(4'd6, 8'h27);
    wr(4'd7, {en[6], 7'd0});
  endtask

  task automatic baseline();
    set_cal('0, '0, '0, '0, '0, '0, '0);
    pulse_cal();
  endtask

  task automatic target();
    set_cal(7'h45, 7'h30, 7'h52, 3'd3, 6'h15, 5'h11, 8'h27);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual running expected done");
    finish_run();
  end

  localparam logic [7:0] RB_EXP [10] = '{8'hFF, 8'hFF, 8'hFF, 8'h87, 8'hBF, 8'h9F, 8'hFF, 8'h80, 8'h01, 8'h00};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), rv);
      check("R1 reset reg", rv, 8'h00);
    end
    check("R1 irq", {7'd0, alarm_irq}, 8'h00);

    // R2 readback masks
    for (int a = 0; a < 10; a++) wr(4'(a), 8'hFF);
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), rv);
      check("R2 readback", rv, RB_EXP[a]);
    end
    rd(4'd12, rv);
    check("R2 unmapped", rv, 8'h00);

    // vector table: R3 R4 R5 R6 R7 R11
    wr(4'd8, 8'h01);
    for (int i = 0; i < 9; i++) begin
      prog(VEC[i].en);
      pulse_per(); pulse_per();
      baseline();
      wr(4'd9, 8'h00);
      set_cal(VEC[i].s, VEC[i].m, VEC[i].h, VEC[i].w, VEC[i].d, VEC[i].mo, VEC[i].y);
      pulse_cal();
      rd(4'd9, rv);
      check("R3/R4/R5/R6/R7 vector flag", rv, {7'd0, VEC[i].exp});
      check("R11 vector irq", {7'd0, alarm_irq}, {7'd0, VEC[i].exp});
    end

    // R8 settle window
    wr(4'd9, 8'h00);
    prog(7'h7F);
    target(); pulse_cal();
    rd(4'd9, rv); check("R8 zero ticks", rv, 8'h00);
    baseline(); pulse_per();
    target(); pulse_cal();
    rd(4'd9, rv); check("R8 one tick", rv, 8'h00);
    baseline();
    wr(4'd0, 8'hC5);
    pulse_per();
    target(); pulse_cal();
    rd(4'd9, rv); check("R8 restart by write", rv, 8'h00);
    baseline(); pulse_per();
    target(); pulse_cal();
    rd(4'd9, rv); check("R8 two ticks", rv, 8'h01);

    // R10 write one keeps, zero clears
    wr(4'd9, 8'h01);
    rd(4'd9, rv); check("R10 write one", rv, 8'h01);
    wr(4'd9, 8'h00);
    rd(4'd9, rv); check("R10 write zero", rv, 8'h00);

    // R9 persistent match does not retrigger
    pulse_cal();
    rd(4'd9, rv); check("R9 persist", rv, 8'h00);
    baseline(); target(); pulse_cal();
    rd(4'd9, rv); check("R9 new edge", rv, 8'h01);

    // R11 gating by enable
    wr(4'd8, 8'h00);
    check("R11 aie off", {7'd0, alarm_irq}, 8'h00);
    wr(4'd8, 8'h01);
    check("R11 aie on", {7'd0, alarm_irq}, 8'h01);

    // R10 set wins over clear in same cycle
    wr(4'd9, 8'h00);
    baseline(); target();
    @(negedge clk);
    cal_tick = 1'b1; reg_we = 1'b1; reg_addr = 4'd9; reg_wdata = 8'h00;
    @(negedge clk);
    cal_tick = 1'b0; reg_we = 1'b0;
    rd(4'd9, rv); check("R10 set beats clear", rv, 8'h01);

    // R12 no strobe, no compare
    wr(4'd9, 8'h00);
    baseline(); target();
    repeat (5) @(negedge clk);
    rd(4'd9, rv); check("R12 no tick", rv, 8'h00);
    check("R12 irq", {7'd0, alarm_irq}, 8'h00);

    finish_run();
  end
endmodule